// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Port

This block combines a set of active-low interrupt request lines into a single active-low interrupt output meant for a CPU interrupt input that is level-sensitive. Lower line numbers win: line 0 beats every other line and the last line loses to all of them. The requests are asynchronous. They pass through a two-stage synchronizer and then a priority encoder.

The block also has a read-only port. It returns the number of the winning line, shifted left by one bit so the value steps by two. The handler entry code can load that byte and use it directly as an index into a table of 2-byte handler addresses, which saves polling each device.

The port value is captured into a holding register on the rising transition of the CPU phase signal. A read in the phase that follows therefore sees a fixed value, even if requests change during the access.

When a handler returns while a lower-priority line is still low, the output stays asserted. The CPU is then interrupted again, and the next capture reports that line.

Top module: `irq_prio_port`

## Requirements
- R1: `irq_n` is 0 whenever at least one `req_n` bit is 0, and 1 when all `req_n` bits are 1.
- R2: Among the active lines (a `req_n` bit equal to 0), the port reports the lowest-numbered one, so line 0 has top priority and line 7 has least.
- R3: With the port read, `rdata[3:1]` holds the winning line number and `rdata[0]` and `rdata[7:4]` are 0, so `rdata` equals twice the line number.
- R4: The holding register loads only on a clock edge where `phi2` is sampled 1 after being sampled 0 on the previous edge. Between such edges, changes on `req_n` do not alter the value read.
- R5: `rdata` is 0 unless `sel` and `rd` are both 1.
- R6: A capture taken while no request is active reads back 0, and in that state `irq_n` is 1.
- R7: When the winning line is released while a lower-priority line stays low, `irq_n` remains 0 and the next capture reports the lower-priority line.
- R8: After synchronous reset (`rst`=1), `irq_n` is 1 and the port reads 0.
- R9: A change on `req_n` appears on `irq_n` after exactly two rising `clk` edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 8 | Active-low interrupt requests, bit 0 has highest priority |
| phi2 | input | 1 | CPU clock phase; rising transition captures the port value |
| sel | input | 1 | Port select, active high |
| rd | input | 1 | Read strobe, active high |
| rdata | output | 8 | Port read data, zero when not selected for read |
| irq_n | output | 1 | Active-low level interrupt to the CPU |

## Verification
The checker runs on every cycle. It confirms that `irq_n` follows the OR of the requests seen two clocks earlier, that the unused data bits stay zero, that the bus is quiet outside a selected read, that the value read does not move without a preceding `phi2` rise, and that reset leaves the output released.

The choice of the lowest-numbered active line, and the chained servicing of a lower-priority source after a higher one is released, can only be shown by the bench. It drives chosen request patterns and compares each captured read against the line number expected for that pattern.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  // Bit shift that turns a line number into a byte offset for a table of
  // handler addresses whose entries are ENTRY_BYTES wide.
  function automatic int entry_shift(input int entry_bytes);
    int s;
    s = 0;
    while ((1 << s) < entry_bytes) s++;
    return s;
  endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_n,
  output logic [WIDTH-1:0] q_n
);
  logic [WIDTH-1:0] stage [STAGES];

  // Stages reset to all ones, which means no request is pending.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '1;
          else     stage[g] <= d_n;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[g] <= '1;
          else     stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q_n = stage[STAGES-1];
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_REQ = 8,
  parameter int IDX_W   = $clog2(NUM_REQ)
) (
  input  logic [NUM_REQ-1:0] act_n,
  output logic [IDX_W-1:0]   win_idx,
  output logic               any_act
);
  // The scan runs from the top index down, so the lowest active index is
  // the last one written and therefore wins.
  always_comb begin
    win_idx = '0;
    any_act = 1'b0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (!act_n[i]) begin
        win_idx = IDX_W'(i);
        any_act = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_port_latch.sv
module irq_port_latch #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8,
  parameter int SHIFT  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phi2,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              sel,
  input  logic              rd,
  output logic [DATA_W-1:0] rdata
);
  localparam int TOP = IDX_W + SHIFT;

  logic             phi2_q;
  logic [IDX_W-1:0] held;
  logic             cap;

  assign cap = phi2 && !phi2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q <= 1'b0;
      held   <= '0;
    end else begin
      phi2_q <= phi2;
      if (cap) held <= idx_in;
    end
  end

  logic [DATA_W-1:0] word;
  always_comb begin
    word = '0;
    word[TOP-1:SHIFT] = held;
  end

  assign rdata = (sel && rd) ? word : '0;
endmodule

// File: rtl/irq_prio_port.sv
module irq_prio_port #(
  parameter int NUM_REQ     = 8,
  parameter int DATA_W      = 8,
  parameter int ENTRY_BYTES = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REQ-1:0] req_n,
  input  logic               phi2,
  input  logic               sel,
  input  logic               rd,
  output logic [DATA_W-1:0]  rdata,
  output logic               irq_n
);
  localparam int IDX_W = $clog2(NUM_REQ);
  localparam int SHIFT = irq_prio_pkg::entry_shift(ENTRY_BYTES);

  logic [NUM_REQ-1:0] req_sync_n;
  logic [IDX_W-1:0]   win_idx;
  logic               any_act;

  irq_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_n (req_n),
    .q_n (req_sync_n)
  );

  irq_prio_enc #(.NUM_REQ(NUM_REQ), .IDX_W(IDX_W)) u_enc (
    .act_n   (req_sync_n),
    .win_idx (win_idx),
    .any_act (any_act)
  );

  irq_port_latch #(.IDX_W(IDX_W), .DATA_W(DATA_W), .SHIFT(SHIFT)) u_latch (
    .clk    (clk),
    .rst    (rst),
    .phi2   (phi2),
    .idx_in (win_idx),
    .sel    (sel),
    .rd     (rd),
    .rdata  (rdata)
  );

  // Driven only from the synchronizer flops.
  assign irq_n = !any_act;
endmodule

// File: rtl/irq_prio_port_chk.sv
module irq_prio_port_chk #(
  parameter int NUM_REQ = 8,
  parameter int DATA_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_n,
  input logic               phi2,
  input logic               sel,
  input logic               rd,
  input logic [DATA_W-1:0]  rdata,
  input logic               irq_n
);
  // Counts cycles since reset, saturating at 3.
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= '0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  // R1 R9
  irq_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2) |-> (irq_n == &$past(req_n, 2)));

  // R3
  unused_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rdata[0] == 1'b0) && (rdata[DATA_W-1:4] == '0));

  // R5
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(sel && rd) |-> (rdata == '0));

  // R4
  read_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ((since_rst >= 2) && sel && rd && $past(sel && rd)
      && !($past(phi2) && !$past(phi2, 2))) |-> (rdata == $past(rdata)));

  // R8
  reset_release_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> irq_n);
endmodule

bind irq_prio_port irq_prio_port_chk #(.NUM_REQ(NUM_REQ), .DATA_W(DATA_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req_n (req_n),
  .phi2  (phi2),
  .sel   (sel),
  .rd    (rd),
  .rdata (rdata),
  .irq_n (irq_n)
);

// File: tb/irq_prio_port_test.sv
module irq_prio_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] req_n = 8'hFF;
  logic       phi2 = 1'b0;
  logic       sel = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] rdata;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_prio_port uut (
    .clk   (clk),
    .rst   (rst),
    .req_n (req_n),
    .phi2  (phi2),
    .sel   (sel),
    .rd    (rd),
    .rdata (rdata),
    .irq_n (irq_n)
  );

  function automatic logic [7:0] expect_read(input logic [7:0] r);
    logic [7:0] v;
    v = 8'h00;
    for (int i = 7; i >= 0; i--) if (!r[i]) v = 8'(i * 2);
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_req(input logic [7:0] v);
    @(negedge clk);
    req_n = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic capture();
    @(negedge clk); phi2 = 1'b1;
    @(negedge clk);
    @(negedge clk); phi2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_port(output logic [7:0] v);
    sel = 1'b1; rd = 1'b1;
    #1 v = rdata;
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    check("R8 irq_n", {7'd0, irq_n}, 8'd1);
    read_port(v);
    check("R8 port", v, 8'h00);
  endtask

  task automatic t_pattern(input logic [7:0] p);
    logic [7:0] v;
    set_req(p); settle(); capture();
    check("R1 irq_n", {7'd0, irq_n}, {7'd0, &p});
    read_port(v);
    check("R2 R3 read", v, expect_read(p));
  endtask

  task automatic t_latency();
    set_req(8'hFF); settle();
    set_req(8'hEF);
    @(negedge clk);
    check("R9 one edge", {7'd0, irq_n}, 8'd1);
    @(negedge clk);
    check("R9 two edges", {7'd0, irq_n}, 8'd0);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    set_req(8'hF7); settle(); capture();
    set_req(8'hFD); settle();
    read_port(v);
    check("R4 hold low phase", v, 8'd6);
    @(negedge clk); phi2 = 1'b1;
    @(negedge clk);
    set_req(8'hFE); settle();
    read_port(v);
    check("R4 hold high phase", v, 8'd2);
    @(negedge clk); phi2 = 1'b0;
    capture();
    read_port(v);
    check("R4 next capture", v, 8'd0);
  endtask

  task automatic t_select();
    set_req(8'h7F); settle(); capture();
    sel = 1'b1; rd = 1'b0; #1 check("R5 sel only", rdata, 8'h00);
    sel = 1'b0; rd = 1'b1; #1 check("R5 rd only", rdata, 8'h00);
    sel = 1'b1; rd = 1'b1; #1 check("R5 both", rdata, 8'd14);
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic t_idle();
    logic [7:0] v;
    set_req(8'hFF); settle(); capture();
    check("R6 irq_n", {7'd0, irq_n}, 8'd1);
    read_port(v);
    check("R6 read", v, 8'h00);
  endtask

  task automatic t_chain();
    logic [7:0] v;
    set_req(8'hDB); settle(); capture();
    read_port(v);
    check("R7 first", v, 8'd4);
    set_req(8'hDF); settle();
    check("R7 irq held", {7'd0, irq_n}, 8'd0);
    capture();
    read_port(v);
    check("R7 second", v, 8'd10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_pattern(8'h7F);
    t_pattern(8'h00);
    t_pattern(8'hB7);
    t_pattern(8'hFE);
    t_latency();
    t_hold();
    t_select();
    t_idle();
    t_chain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule